// File: doc/BRIEF.md
# Page Write Buffer with Programming Timer

This block sits behind a serial memory command decoder and collects the data bytes of one write frame into a 128-byte page. When a frame starts it takes a start address. The upper address bits select the page and stay fixed for the whole frame. The low seven bits give the first slot, and that slot index steps forward by one for each accepted byte, wrapping modulo 128. If more than a page of data arrives, later bytes replace earlier ones in the same slots.

When the decoder reports that chip select rose at a legal point (a commit), the block becomes busy. It streams every slot that received data to the memory array, in ascending slot order, over a valid/ready port. It then holds busy for a programmable number of cycles that model the internal programming time. When that time runs out, busy drops and the block emits a one-cycle pulse that clears the write-enable latch. A frame ended at an illegal point (an abort) is discarded, and the block never becomes busy for it. A commit that carries fewer than 128 bytes still programs the received slots, and it raises a flag that marks the page as incomplete.

Back-pressure rules: the input stream is accepted only while a frame is open (`in_ready` high), and one byte is taken on each cycle where `in_valid` and `in_ready` are both high. The array port offers one write at a time. Address and data hold steady until `arr_ready` is sampled high, and a write counts as done on that cycle.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, busy, in_ready, arr_valid, wel_clr and page_partial are all low.
- R2: A frm_start pulse while idle opens a frame. in_ready goes high in the next cycle. Address bits [15:7] become the page, and bits [6:0] become the first slot.
- R3: Each accepted byte is stored at the current slot, and the slot then increments modulo 128. Every array write carries the frame's page in address bits [15:7] and the slot in bits [6:0].
- R4: When more than 128 bytes are accepted, the slot wraps and the later byte overwrites the earlier one. Each slot is written to the array once, carrying its last value.
- R5: A commit with at least one accepted byte raises busy in the next cycle. Exactly one array write is then issued per distinct slot received, in ascending slot order.
- R6: While arr_valid is high and arr_ready is low, arr_valid, arr_addr and arr_data stay unchanged in the next cycle.
- R7: The scan visits all 128 slots. In the cycle after slot 127 is passed, a timer starts that keeps busy high for max(prog_cycles,1) cycles. In the first cycle with busy low, wel_clr is high for exactly one cycle.
- R8: page_partial is set at commit when fewer than 128 bytes were accepted, and cleared otherwise. It holds its value until the next frame opens.
- R9: A frm_abort during a frame (alone, with a byte, or with a commit) discards the buffer. It produces no array write, no busy and no wel_clr, and a later frame flushes none of the discarded bytes.
- R10: A byte accepted in the same cycle as the commit is part of the page.
- R11: A commit with no accepted byte closes the frame without array writes, busy or wel_clr.
- R12: frm_start, input bytes and commits that arrive while busy are ignored: in_ready stays low and no extra array write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Opens a write frame (pulse) |
| frm_addr | input | 16 | Start address of the frame |
| frm_commit | input | 1 | Frame ended at a legal point (pulse) |
| frm_abort | input | 1 | Frame ended at an illegal point (pulse) |
| prog_cycles | input | 16 | Programming time in cycles, latched when the timer starts |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block accepts data bytes |
| in_data | input | 8 | Data byte |
| arr_valid | output | 1 | Array write offered |
| arr_ready | input | 1 | Array accepts the write |
| arr_addr | output | 16 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Programming in progress |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |
| page_partial | output | 1 | Last committed page had fewer than 128 bytes |

## Verification
Byte capture and frame closing can fall in the same cycle. The last byte can arrive together with the commit, or together with an abort. The bench drives both pairings. A same-cycle byte must appear among the array writes after a commit. After an abort, nothing may reach the array and busy must stay low. The vector table also mixes wrapping frames with a toggling arr_ready, so that stalled array writes and slot overwrites meet in the same flush.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_WAIT  = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int PAGE = 128,
  parameter int DW   = 8,
  parameter int IW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            we_i,
  input  logic [IW-1:0]   widx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IW-1:0]   ridx_i,
  output logic [DW-1:0]   rdata_o,
  output logic [PAGE-1:0] mask_o
);
  logic [DW-1:0] slot_q [PAGE];

  for (genvar g = 0; g < PAGE; g++) begin : gen_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_o[g] <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (we_i && widx_i == IW'(g)) begin
        mask_o[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we_i && widx_i == IW'(g)) slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[ridx_i];

  // R9: a clear leaves no slot marked as written
  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_o == '0));
endmodule

// File: rtl/pwb_flush_scan.sv
module pwb_flush_scan #(
  parameter int PAGE = 128,
  parameter int IW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PAGE-1:0] mask_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic            done_o
);
  logic          active_q;
  logic [IW-1:0] ptr_q;
  logic          step;
  logic          last;

  assign valid_o = active_q && mask_i[ptr_q];
  assign step    = active_q && (!mask_i[ptr_q] || ready_i);
  assign last    = (ptr_q == IW'(PAGE - 1));
  assign done_o  = step && last;
  assign idx_o   = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      ptr_q    <= '0;
    end else if (step) begin
      if (last) active_q <= 1'b0;
      else      ptr_q    <= ptr_q + IW'(1);
    end
  end

  // R5: the scan only moves forward while it is active
  p_scan_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && step && !last && !start_i) |=> (ptr_q == $past(ptr_q) + IW'(1)));
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] load_i,
  output logic          expire_o,
  output logic          running_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o  = run_q && (cnt_q <= CW'(1));
  assign running_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= load_i;
    end else if (expire_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R7: once started, the timer keeps running until it expires
  p_timer_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !expire_o) |=> run_q);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic              frm_commit,
  input  logic              frm_abort,
  input  logic [CNT_W-1:0]  prog_cycles,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              wel_clr,
  output logic              page_partial
);
  import pwb_pkg::*;

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - IDX_W;
  localparam int FILL_W = IDX_W + 1;

  pwb_state_e        state_q;
  logic [HI_W-1:0]   page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_next;
  logic              partial_q;
  logic              wel_q;

  logic              byte_fire;
  logic              in_frame;
  logic              drop;
  logic              commit_ok;
  logic              open_frame;

  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_data;
  logic [IDX_W-1:0]      scan_idx;
  logic                  scan_done;
  logic                  tmr_expire;
  logic                  tmr_running;

  assign in_frame   = (state_q == ST_FILL);
  assign in_ready   = in_frame;
  assign byte_fire  = in_valid && in_frame;
  assign fill_next  = (fill_q == FILL_W'(PAGE_BYTES)) ? fill_q
                                                      : fill_q + FILL_W'(byte_fire);
  assign drop       = in_frame && (frm_abort || (frm_commit && fill_next == '0));
  assign commit_ok  = in_frame && frm_commit && !frm_abort && (fill_next != '0);
  assign open_frame = (state_q == ST_IDLE) && frm_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      idx_q     <= '0;
      fill_q    <= '0;
      partial_q <= 1'b0;
      wel_q     <= 1'b0;
    end else begin
      wel_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (frm_start) begin
            state_q   <= ST_FILL;
            page_q    <= frm_addr[ADDR_W-1:IDX_W];
            idx_q     <= frm_addr[IDX_W-1:0];
            fill_q    <= '0;
            partial_q <= 1'b0;
          end
        end
        ST_FILL: begin
          if (byte_fire) begin
            idx_q  <= idx_q + IDX_W'(1);
            fill_q <= fill_next;
          end
          if (drop) begin
            state_q <= ST_IDLE;
          end else if (commit_ok) begin
            state_q   <= ST_FLUSH;
            partial_q <= (fill_next < FILL_W'(PAGE_BYTES));
          end
        end
        ST_FLUSH: begin
          if (scan_done) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_expire) begin
            state_q <= ST_IDLE;
            wel_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pwb_page_store #(
    .PAGE (PAGE_BYTES),
    .DW   (DATA_W),
    .IW   (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (open_frame || drop),
    .we_i    (byte_fire),
    .widx_i  (idx_q),
    .wdata_i (in_data),
    .ridx_i  (scan_idx),
    .rdata_o (rd_data),
    .mask_o  (mask)
  );

  pwb_flush_scan #(
    .PAGE (PAGE_BYTES),
    .IW   (IDX_W)
  ) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit_ok),
    .mask_i  (mask),
    .ready_i (arr_ready),
    .valid_o (arr_valid),
    .idx_o   (scan_idx),
    .done_o  (scan_done)
  );

  pwb_prog_timer #(
    .CW (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (scan_done),
    .load_i    (prog_cycles),
    .expire_o  (tmr_expire),
    .running_o (tmr_running)
  );

  assign arr_addr     = {page_q, scan_idx};
  assign arr_data     = rd_data;
  assign busy         = (state_q == ST_FLUSH) || (state_q == ST_WAIT);
  assign wel_clr      = wel_q;
  assign page_partial = partial_q;

  // R5: busy only starts after a commit
  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_commit));

  // R6: a stalled array write holds steady
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data)));

  // R7: latch-clear pulse lands on the first idle cycle and lasts one cycle
  p_wel_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!busy && $past(busy)));
  p_wel_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  // R7: the timer runs only while the block is busy
  p_timer_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_running |-> busy);

  // R9: an aborted frame never turns busy
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && frm_abort) |=> !busy);

  // R12: no byte is taken while busy
  p_no_take_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

// File: tb/pwb_page_writer_test.sv
`timescale 1ns/1ps
module pwb_page_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 1'b0;
  logic [15:0] frm_addr = '0;
  logic        frm_commit = 1'b0;
  logic        frm_abort = 1'b0;
  logic [15:0] prog_cycles = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        arr_valid;
  logic        arr_ready = 1'b1;
  logic [15:0] arr_addr;
  logic [7:0]  arr_data;
  logic        busy;
  logic        wel_clr;
  logic        page_partial;

  pwb_page_writer uut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_addr(frm_addr),
    .frm_commit(frm_commit), .frm_abort(frm_abort), .prog_cycles(prog_cycles),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data), .busy(busy), .wel_clr(wel_clr), .page_partial(page_partial)
  );

  always #2.5 clk = ~clk;

  // vector table: address, byte count, data seed, prog cycles,
  // ready toggling, commit with last byte, expected writes, expected partial
  localparam int NV = 6;
  localparam int V_ADDR [NV] = '{'h1200, 'h3470, 'hFFFE, 'h0005, 'h8080, 'h4A3F};
  localparam int V_N    [NV] = '{128, 20, 130, 1, 200, 3};
  localparam int V_SEED [NV] = '{'h10, 'h21, 'h33, 'h44, 'h55, 'h66};
  localparam int V_P    [NV] = '{5, 3, 1, 0, 7, 12};
  localparam int V_RDY  [NV] = '{0, 1, 0, 1, 1, 0};
  localparam int V_SAME [NV] = '{0, 1, 0, 0, 1, 0};
  localparam int V_W    [NV] = '{128, 20, 128, 1, 128, 3};
  localparam int V_PART [NV] = '{0, 1, 0, 1, 0, 1};

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int cyc = 0;
  int got_n = 0;
  logic [15:0] got_addr [512];
  logic [7:0]  got_data [512];
  int last_fire = 0;
  int fall_cyc = -1;
  int wel_n = 0;
  int wel_cyc = -1;
  int busy_hi_n = 0;
  int stall_n = 0;
  int stall_bad = 0;
  bit stall_prev = 0;
  logic [15:0] pa;
  logic [7:0]  pd;
  bit busy_prev = 0;
  int rdy_mode = 0;
  int rph = 0;

  logic [7:0] mval [128];
  bit         mmsk [128];

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge clk) begin
    #1;
    rph = rph + 1;
    arr_ready = (rdy_mode == 0) ? 1'b1 : rph[0];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        stall_n = stall_n + 1;
        if (!(arr_valid && arr_addr == pa && arr_data == pd)) stall_bad = stall_bad + 1;
      end
      stall_prev = arr_valid && !arr_ready;
      pa = arr_addr;
      pd = arr_data;
      if (arr_valid && arr_ready) begin
        if (got_n < 512) begin
          got_addr[got_n] = arr_addr;
          got_data[got_n] = arr_data;
        end
        got_n = got_n + 1;
        last_fire = cyc;
      end
      if (busy) busy_hi_n = busy_hi_n + 1;
      if (busy_prev && !busy) fall_cyc = cyc;
      if (wel_clr) begin
        wel_n = wel_n + 1;
        wel_cyc = cyc;
      end
      busy_prev = busy;
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs;
    got_n = 0;
    wel_n = 0;
    wel_cyc = -1;
    fall_cyc = -1;
    busy_hi_n = 0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 2000 && busy; k++) tick();
    tick();
    tick();
  endtask

  task automatic run_frame(int addr, int n, int seed, int p, int rmode,
                           int same, int exp_w, int exp_part, bit poke);
    int lo;
    int hi_l;
    int bad;
    int prev_idx;
    int pe;
    string dreq;
    for (int i = 0; i < 128; i++) mmsk[i] = 0;
    lo = addr % 128;
    clear_obs();
    rdy_mode = rmode;
    prog_cycles = 16'(p);
    frm_addr = 16'(addr);
    frm_start = 1'b1;
    tick();
    frm_start = 1'b0;
    check(in_ready == 1'b1, "R2", "in_ready after start", in_ready, 1);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data = 8'(seed + 3 * i);
      mval[(lo + i) % 128] = 8'(seed + 3 * i);
      mmsk[(lo + i) % 128] = 1;
      if (same != 0 && i == n - 1) frm_commit = 1'b1;
      tick();
    end
    in_valid = 1'b0;
    if (same == 0) begin
      frm_commit = 1'b1;
      tick();
    end
    frm_commit = 1'b0;
    check(busy == 1'b1, "R5", "busy after commit", busy, 1);
    if (poke) begin
      // R12: traffic during busy must be ignored
      frm_start = 1'b1;
      frm_addr = 16'h7700;
      in_valid = 1'b1;
      in_data = 8'hEE;
      for (int k = 0; k < 8; k++) begin
        check(in_ready == 1'b0, "R12", "in_ready while busy", in_ready, 0);
        frm_commit = (k == 4);
        tick();
      end
      frm_start = 1'b0;
      in_valid = 1'b0;
      frm_commit = 1'b0;
    end
    wait_idle();
    if (poke) check(in_ready == 1'b0, "R12", "start while busy opened a frame", in_ready, 0);
    check(got_n == exp_w, (same != 0) ? "R10" : "R5", "array write count", got_n, exp_w);
    bad = 0;
    prev_idx = -1;
    hi_l = 0;
    for (int j = 0; j < got_n && j < 512; j++) begin
      int ix;
      ix = int'(got_addr[j][6:0]);
      if (got_addr[j][15:7] != 9'(addr >> 7)) bad = bad + 1;
      if (ix <= prev_idx) bad = bad + 1;
      if (!mmsk[ix] || got_data[j] != mval[ix]) bad = bad + 1;
      prev_idx = ix;
      hi_l = ix;
    end
    dreq = (n > 128) ? "R4" : "R3";
    check(bad == 0, dreq, "array address/data/order mismatches", bad, 0);
    pe = (p < 1) ? 1 : p;
    check(fall_cyc == last_fire + 128 - hi_l + pe, "R7", "busy fall cycle",
          fall_cyc, last_fire + 128 - hi_l + pe);
    check(wel_n == 1 && wel_cyc == fall_cyc, "R7", "wel_clr pulses/cycle", wel_n, 1);
    check(page_partial == 1'(exp_part), "R8", "page_partial", page_partial, exp_part);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
    check(arr_valid == 1'b0, "R1", "arr_valid", arr_valid, 0);
    check(wel_clr == 1'b0, "R1", "wel_clr", wel_clr, 0);
    check(page_partial == 1'b0, "R1", "page_partial", page_partial, 0);

    for (int v = 0; v < NV; v++)
      run_frame(V_ADDR[v], V_N[v], V_SEED[v], V_P[v], V_RDY[v], V_SAME[v],
                V_W[v], V_PART[v], 1'b0);

    // R9: abort, with a byte in the same cycle
    clear_obs();
    frm_addr = 16'h0A10;
    frm_start = 1'b1;
    tick();
    frm_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1;
      in_data = 8'(i);
      frm_abort = (i == 4);
      tick();
    end
    in_valid = 1'b0;
    frm_abort = 1'b0;
    check(in_ready == 1'b0, "R9", "frame still open after abort", in_ready, 0);
    repeat (20) tick();
    check(busy_hi_n == 0, "R9", "busy cycles after abort", busy_hi_n, 0);
    check(got_n == 0, "R9", "array writes after abort", got_n, 0);
    check(wel_n == 0, "R9", "wel_clr after abort", wel_n, 0);
    // R9: later frame must not flush discarded bytes
    run_frame('h0A40, 1, 'h77, 2, 0, 0, 1, 1, 1'b0);

    // R9: abort together with commit
    clear_obs();
    frm_addr = 16'h0B00;
    frm_start = 1'b1;
    tick();
    frm_start = 1'b0;
    in_valid = 1'b1;
    in_data = 8'h5A;
    tick();
    in_valid = 1'b0;
    frm_commit = 1'b1;
    frm_abort = 1'b1;
    tick();
    frm_commit = 1'b0;
    frm_abort = 1'b0;
    repeat (20) tick();
    check(busy_hi_n == 0 && got_n == 0, "R9", "busy/writes after abort+commit", busy_hi_n + got_n, 0);

    // R11: zero-byte commit
    clear_obs();
    frm_addr = 16'h0C00;
    frm_start = 1'b1;
    tick();
    frm_start = 1'b0;
    frm_commit = 1'b1;
    tick();
    frm_commit = 1'b0;
    check(in_ready == 1'b0, "R11", "frame closed", in_ready, 0);
    repeat (20) tick();
    check(busy_hi_n == 0, "R11", "busy cycles", busy_hi_n, 0);
    check(got_n == 0 && wel_n == 0, "R11", "writes plus wel pulses", got_n + wel_n, 0);

    // R12: traffic while busy
    run_frame('h2200, 4, 'h90, 40, 1, 0, 4, 1, 1'b1);

    // R6: stalls were exercised and held
    check(stall_n > 0, "R6", "stall events seen", stall_n, 1);
    check(stall_bad == 0, "R6", "stalled write changed", stall_bad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule